// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the programmable state store of an interrupt distributor. It holds, for a parameterised number of interrupt lines, one enable bit, one pending bit, one active bit, an 8-bit priority, an 8-bit processor target and a 2-bit trigger configuration. Software reaches this state through a small register bus that carries a word or byte-lane access together with the identifier of the processor that makes it. The state leaves the block as flat vectors that a downstream priority selector consumes.

Each bit array is reached through two address windows. Writing to the set window ORs the data into the state, and writing to the clear window removes the data bits from the state. The two windows read back the same state word. Interrupt numbers 0 to 31 are private to each processor: their enable, pending, active and priority entries exist once per processor, and the requester identifier selects which copy an access uses. Lines 32 and above exist only once and all processors share them. Peripheral request pulses set the pending bit of shared lines. Processor acknowledge, winner selection and pin sampling sit in other blocks.

Top module: `gicd_regfile`

## Requirements
- R1: After reset every enable, pending, active, priority and configuration entry is zero, `rdata_o` is zero and `err_o` is low.
- R2: Enable words sit at byte offset 0x100 + 4*w (set) and 0x180 + 4*w (clear), and word w covers lines 32*w to 32*w+31. A set write ORs the data into the word. A clear write ANDs the word with the inverted data. A read of either window returns the word.
- R3: Pending words use 0x200 (set) and 0x280 (clear) with the same semantics as R2. On word 0, data bits 15:0 are masked off, so those pending bits never change through the bus.
- R4: Active words use 0x300 (set) and 0x380 (clear) with the same semantics as R2 and no masking.
- R5: Word 0 of the enable, pending and active arrays is banked per processor and selected by `cpu_i`. Words 1 and above are shared, so every requester reads and writes the same copy.
- R6: The priority of line n is the byte at offset 0x400 + n. `size_i` 0, 1 and 2 access 1, 2 and 4 consecutive lines, with line n in data bits 7:0 and later lines in higher byte lanes. Lanes beyond the last line are dropped on write and read as zero. Priorities of lines 0 to 31 are banked per processor.
- R7: A write to the priority window with `size_i` = 3 changes nothing and raises `err_o` for exactly the following cycle.
- R8: The target of line n is the byte at offset 0x800 + n, with the same lane rules as R6. Writes to lines 0 to 31 are ignored, and those bytes read as a one-hot mask of the requesting processor (bit `cpu_i` set).
- R9: Configuration word w (2 bits per line, 16 lines per word) sits at 0xC00 + 4*w and is written and read whole.
- R10: Offset 0x004 reads ((NUM_CPUS-1) << 5) | (NUM_LINES/32 - 1), and writes to it are ignored.
- R11: A one-cycle pulse on `periph_set_i[n]` with n >= 32 sets pending bit n for all processors. A pulse wins over a clear write to the same bit in the same cycle. Pulses on lines below 32 have no effect.
- R12: Unmapped offsets, and word indices at or beyond the number of lines, read as zero, and writes to them are ignored.
- R13: A read request updates `rdata_o` at the next clock edge, and `rdata_o` holds its value until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = unsupported |
| cpu_i | input | CPU_W | Identifier of the requesting processor |
| wdata_i | input | 32 | Write data, little-endian lanes |
| rdata_o | output | 32 | Read data, valid from the cycle after a read request |
| err_o | output | 1 | One-cycle pulse for an unsupported priority write size |
| periph_set_i | input | NUM_LINES | Peripheral pending-set pulses |
| enable_o | output | NUM_CPUS*NUM_LINES | Enable state as each processor sees it |
| pending_o | output | NUM_CPUS*NUM_LINES | Pending state as each processor sees it |
| active_o | output | NUM_CPUS*NUM_LINES | Active state as each processor sees it |
| prio_o | output | NUM_CPUS*NUM_LINES*8 | Priority bytes as each processor sees them |
| target_o | output | NUM_CPUS*NUM_LINES*8 | Target bytes as each processor sees them |
| config_o | output | 2*NUM_LINES | Configuration bits |

## Verification
The bench builds the block with 96 lines and 3 processors. Three words per bit array let it show a shared word, a banked word and an out-of-range word index at offset 0x10C. The type value becomes 0x42, which exercises both fields. A third processor shows that banking separates more than one pair of copies. A 4-byte priority write at line 94 shows that lanes beyond the last line are dropped.

// File: rtl/gicd_pkg.sv
package gicd_pkg;

  typedef enum logic [3:0] {
    WIN_NONE, WIN_TYPE, WIN_EN_SET, WIN_EN_CLR, WIN_PD_SET, WIN_PD_CLR,
    WIN_AC_SET, WIN_AC_CLR, WIN_PRIO, WIN_TGT, WIN_CFG
  } win_e;

  function automatic win_e win_decode(input logic [11:0] a);
    win_e w;
    w = WIN_NONE;
    if (a == 12'h004) w = WIN_TYPE;
    else if (a[11:10] == 2'b00) begin
      case (a[9:7])
        3'd2:    w = WIN_EN_SET;
        3'd3:    w = WIN_EN_CLR;
        3'd4:    w = WIN_PD_SET;
        3'd5:    w = WIN_PD_CLR;
        3'd6:    w = WIN_AC_SET;
        3'd7:    w = WIN_AC_CLR;
        default: w = WIN_NONE;
      endcase
    end
    else if (a[11:10] == 2'b01) w = WIN_PRIO;
    else if (a[11:10] == 2'b10) w = WIN_TGT;
    else if (a[11:8] == 4'hC)   w = WIN_CFG;
    return w;
  endfunction

  // byte lanes touched by an access size
  function automatic logic [3:0] size_lanes(input logic [1:0] s);
    case (s)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/gicd_bitbank.sv
module gicd_bitbank #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned CPU_W     = 1,
  parameter logic [31:0] LOCK_MASK = 32'hFFFF_FFFF,
  parameter bit          HW_SET    = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_i,
  input  logic                          clr_i,
  input  logic [4:0]                    widx_i,
  input  logic [CPU_W-1:0]              cpu_i,
  input  logic [31:0]                   wdata_i,
  input  logic [NUM_LINES-1:32]         hw_set_i,
  output logic [31:0]                   rd_word_o,
  output logic [NUM_CPUS*NUM_LINES-1:0] view_o
);
  localparam int unsigned NWORDS = NUM_LINES / 32;
  localparam int unsigned NGLOB  = NWORDS - 1;

  logic [31:0] bnk_q  [NUM_CPUS];
  logic [31:0] glob_q [NGLOB];
  logic [NUM_LINES-33:0] glob_flat;
  logic [31:0] wmask;

  assign wmask = (widx_i == 5'd0) ? (wdata_i & LOCK_MASK) : wdata_i;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bnk_q[c] <= '0;
      else if (widx_i == 5'd0 && cpu_i == CPU_W'(c)) begin
        if (set_i)      bnk_q[c] <= bnk_q[c] | wmask;
        else if (clr_i) bnk_q[c] <= bnk_q[c] & ~wmask;
      end
    end

    assign view_o[c*NUM_LINES +: 32] = bnk_q[c];
    for (genvar g = 0; g < NGLOB; g++) begin : g_share
      assign view_o[c*NUM_LINES + 32*(g+1) +: 32] = glob_q[g];
    end

    // R5: a word-0 access by another requester leaves this copy alone
    a_r5_bank_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((set_i || clr_i) && widx_i == 5'd0 && cpu_i != CPU_W'(c)) |=> $stable(bnk_q[c]));

    if (LOCK_MASK != 32'hFFFF_FFFF) begin : g_lock_chk
      a_r3_locked_bits_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(bnk_q[c] & ~LOCK_MASK));
    end
  end

  for (genvar g = 0; g < NGLOB; g++) begin : g_glob
    logic        hit;
    logic [31:0] hw, nxt;
    assign hit = (widx_i == 5'(g + 1));
    assign hw  = hw_set_i[32*(g+1) +: 32] & {32{HW_SET}};
    always_comb begin
      nxt = glob_q[g];
      if (hit && set_i) nxt = nxt | wdata_i;
      if (hit && clr_i) nxt = nxt & ~wdata_i;
      nxt = nxt | hw;  // peripheral set wins over a same-cycle clear
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) glob_q[g] <= '0;
      else         glob_q[g] <= nxt;
    end
    assign glob_flat[32*g +: 32] = glob_q[g];
  end

  always_comb begin
    rd_word_o = '0;
    if (widx_i == 5'd0) begin
      for (int c = 0; c < NUM_CPUS; c++)
        if (cpu_i == CPU_W'(c)) rd_word_o = bnk_q[c];
    end else begin
      for (int g = 0; g < NGLOB; g++)
        if (widx_i == 5'(g + 1)) rd_word_o = glob_q[g];
    end
  end

  if (HW_SET) begin : g_hw_chk
    a_r11_hw_pulse_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|hw_set_i) |=> ((glob_flat & $past(hw_set_i)) == $past(hw_set_i)));
  end

endmodule

// File: rtl/gicd_bytebank.sv
module gicd_bytebank #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned CPU_W     = 1,
  parameter bit          LOW_FIXED = 1'b0
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [3:0]                      lanes_i,
  input  logic [9:0]                      base_i,
  input  logic [CPU_W-1:0]                cpu_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rd_word_o,
  output logic [NUM_CPUS*NUM_LINES*8-1:0] view_o
);
  localparam int unsigned NGLOB = NUM_LINES - 32;
  localparam int unsigned VW    = NUM_LINES * 8;

  logic [10:0] lane_idx [4];
  logic [7:0]  glob_q [NGLOB];
  logic [NGLOB*8-1:0] glob_flat;
  logic [VW-1:0] sel_view;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_idx[k] = {1'b0, base_i} + 11'(k);
  end

  for (genvar l = 32; l < NUM_LINES; l++) begin : g_glob
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) glob_q[l-32] <= '0;
      else if (wr_i) begin
        for (int k = 0; k < 4; k++)
          if (lanes_i[k] && lane_idx[k] == 11'(l)) glob_q[l-32] <= wdata_i[8*k +: 8];
      end
    end
    assign glob_flat[8*(l-32) +: 8] = glob_q[l-32];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar l = 0; l < 32; l++) begin : g_low
      if (LOW_FIXED) begin : g_fixed
        assign view_o[(c*NUM_LINES + l)*8 +: 8] = 8'(1) << c;
      end else begin : g_store
        logic [7:0] bnk_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) bnk_q <= '0;
          else if (wr_i && cpu_i == CPU_W'(c)) begin
            for (int k = 0; k < 4; k++)
              if (lanes_i[k] && lane_idx[k] == 11'(l)) bnk_q <= wdata_i[8*k +: 8];
          end
        end
        assign view_o[(c*NUM_LINES + l)*8 +: 8] = bnk_q;
      end
    end
    for (genvar l = 32; l < NUM_LINES; l++) begin : g_high
      assign view_o[(c*NUM_LINES + l)*8 +: 8] = glob_q[l-32];
    end
  end

  always_comb begin
    sel_view = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (cpu_i == CPU_W'(c)) sel_view = view_o[c*VW +: VW];
  end

  always_comb begin
    rd_word_o = '0;
    for (int k = 0; k < 4; k++)
      if (lanes_i[k] && lane_idx[k] < 11'(NUM_LINES))
        rd_word_o[8*k +: 8] = sel_view[lane_idx[k]*8 +: 8];
  end

  a_r6_shared_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(glob_flat));

endmodule

// File: rtl/gicd_regfile.sv
module gicd_regfile
  import gicd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_CPUS  = 2,
  parameter int unsigned CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [11:0]                     addr_i,
  input  logic [1:0]                      size_i,
  input  logic [CPU_W-1:0]                cpu_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  output logic                            err_o,
  input  logic [NUM_LINES-1:0]            periph_set_i,
  output logic [NUM_CPUS*NUM_LINES-1:0]   enable_o,
  output logic [NUM_CPUS*NUM_LINES-1:0]   pending_o,
  output logic [NUM_CPUS*NUM_LINES-1:0]   active_o,
  output logic [NUM_CPUS*NUM_LINES*8-1:0] prio_o,
  output logic [NUM_CPUS*NUM_LINES*8-1:0] target_o,
  output logic [2*NUM_LINES-1:0]          config_o
);
  localparam int unsigned CFG_WORDS = NUM_LINES / 16;
  localparam logic [31:0] TYPE_VAL  = 32'(((NUM_CPUS - 1) << 5) | (NUM_LINES / 32 - 1));
  localparam logic [31:0] SGI_LOCK  = 32'hFFFF_0000;

  win_e        win;
  logic        wr, rd, size_ok, bad_prio;
  logic [3:0]  lanes;
  logic [4:0]  widx;
  logic [5:0]  cidx;
  logic [31:0] en_rd, pd_rd, ac_rd, pr_rd, tg_rd, cfg_rd, rd_mux;
  logic [31:0] cfg_q [CFG_WORDS];
  logic [31:0] rdata_q;
  logic        err_q;

  assign win      = win_decode(addr_i);
  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign widx     = addr_i[6:2];
  assign cidx     = addr_i[7:2];
  assign lanes    = size_lanes(size_i);
  assign size_ok  = (size_i != 2'd3);
  assign bad_prio = wr && win == WIN_PRIO && !size_ok;

  gicd_bitbank #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
                 .LOCK_MASK(32'hFFFF_FFFF), .HW_SET(1'b0)) u_enable (
    .clk_i, .rst_ni,
    .set_i(wr && win == WIN_EN_SET), .clr_i(wr && win == WIN_EN_CLR),
    .widx_i(widx), .cpu_i, .wdata_i, .hw_set_i('0),
    .rd_word_o(en_rd), .view_o(enable_o));

  gicd_bitbank #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
                 .LOCK_MASK(SGI_LOCK), .HW_SET(1'b1)) u_pending (
    .clk_i, .rst_ni,
    .set_i(wr && win == WIN_PD_SET), .clr_i(wr && win == WIN_PD_CLR),
    .widx_i(widx), .cpu_i, .wdata_i, .hw_set_i(periph_set_i[NUM_LINES-1:32]),
    .rd_word_o(pd_rd), .view_o(pending_o));

  gicd_bitbank #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
                 .LOCK_MASK(32'hFFFF_FFFF), .HW_SET(1'b0)) u_active (
    .clk_i, .rst_ni,
    .set_i(wr && win == WIN_AC_SET), .clr_i(wr && win == WIN_AC_CLR),
    .widx_i(widx), .cpu_i, .wdata_i, .hw_set_i('0),
    .rd_word_o(ac_rd), .view_o(active_o));

  gicd_bytebank #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
                  .LOW_FIXED(1'b0)) u_prio (
    .clk_i, .rst_ni, .wr_i(wr && win == WIN_PRIO && size_ok), .lanes_i(lanes),
    .base_i(addr_i[9:0]), .cpu_i, .wdata_i, .rd_word_o(pr_rd), .view_o(prio_o));

  gicd_bytebank #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W),
                  .LOW_FIXED(1'b1)) u_target (
    .clk_i, .rst_ni, .wr_i(wr && win == WIN_TGT && size_ok), .lanes_i(lanes),
    .base_i(addr_i[9:0]), .cpu_i, .wdata_i, .rd_word_o(tg_rd), .view_o(target_o));

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[w] <= '0;
      else if (wr && win == WIN_CFG && cidx == 6'(w)) cfg_q[w] <= wdata_i;
    end
    assign config_o[32*w +: 32] = cfg_q[w];
  end

  always_comb begin
    cfg_rd = '0;
    for (int w = 0; w < CFG_WORDS; w++)
      if (cidx == 6'(w)) cfg_rd = cfg_q[w];
  end

  always_comb begin
    case (win)
      WIN_TYPE:               rd_mux = TYPE_VAL;
      WIN_EN_SET, WIN_EN_CLR: rd_mux = en_rd;
      WIN_PD_SET, WIN_PD_CLR: rd_mux = pd_rd;
      WIN_AC_SET, WIN_AC_CLR: rd_mux = ac_rd;
      WIN_PRIO:               rd_mux = pr_rd;
      WIN_TGT:                rd_mux = tg_rd;
      WIN_CFG:                rd_mux = cfg_rd;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      err_q <= bad_prio;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  a_r7_err_needs_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && we_i && addr_i[11:10] == 2'b01 && size_i == 2'd3));

  a_r12_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && win == WIN_NONE) |=> (rdata_o == 32'd0));

  a_r13_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  a_r10_type_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 12'h004) |=> (rdata_o == TYPE_VAL));

endmodule

// File: tb/tb_gicd_regfile.sv
module tb_gicd_regfile;
  localparam int unsigned NL = 96;
  localparam int unsigned NC = 3;
  localparam int unsigned CW = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0;
  logic [11:0]       addr_i = '0;
  logic [1:0]        size_i = '0;
  logic [CW-1:0]     cpu_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              err_o;
  logic [NL-1:0]     periph_set_i = '0;
  logic [NC*NL-1:0]  enable_o, pending_o, active_o;
  logic [NC*NL*8-1:0] prio_o, target_o;
  logic [2*NL-1:0]   config_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        chk_due = 1'b0;

  always #2 clk = ~clk;

  gicd_regfile #(.NUM_LINES(NL), .NUM_CPUS(NC), .CPU_W(CW)) dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .size_i, .cpu_i, .wdata_i,
    .rdata_o, .err_o, .periph_set_i, .enable_o, .pending_o, .active_o,
    .prio_o, .target_o, .config_o);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data the cycle after each read request
  always @(posedge clk) chk_due <= req_i & ~we_i;
  always @(negedge clk) begin
    if (chk_due && exp_q.size() > 0) chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [11:0] a, input int c, input logic [1:0] s, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; cpu_i = CW'(c); size_i = s; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, input int c, input logic [1:0] s,
                    input logic [31:0] e, input string tag);
    req_i = 1; we_i = 0; addr_i = a; cpu_i = CW'(c); size_i = s;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({31'd0, err_o}, 32'd0, "R1 err_o");
    chk(32'(|{enable_o, pending_o, active_o, prio_o, config_o}), 32'd0, "R1 state zero");
    rd(12'h100, 0, 2, 32'd0, "R1 enable word0");

    // R2 enable set/clear
    wr(12'h100, 0, 2, 32'hF0F0_0001);
    wr(12'h100, 0, 2, 32'h0000_0100);
    rd(12'h180, 0, 2, 32'hF0F0_0101, "R2 set ORs, clear alias reads");
    wr(12'h180, 0, 2, 32'hF000_0001);
    rd(12'h100, 0, 2, 32'h00F0_0100, "R2 clear ANDs inverse");
    chk({31'd0, enable_o[0*NL+8]}, 32'd1, "R2 enable view bit 8");

    // R5 banking vs shared
    wr(12'h104, 1, 2, 32'hAAAA_5555);
    rd(12'h184, 2, 2, 32'hAAAA_5555, "R5 shared word1");
    rd(12'h100, 1, 2, 32'd0, "R5 banked word0 other cpu");

    // R3 pending with locked low bits
    wr(12'h200, 0, 2, 32'hFFFF_FFFF);
    rd(12'h280, 0, 2, 32'hFFFF_0000, "R3 sgi bits locked on set");
    wr(12'h280, 0, 2, 32'h0001_FFFF);
    rd(12'h200, 0, 2, 32'hFFFE_0000, "R3 sgi bits locked on clear");
    wr(12'h204, 2, 2, 32'h0000_00FF);
    wr(12'h284, 2, 2, 32'h0000_000F);
    rd(12'h204, 0, 2, 32'h0000_00F0, "R3 word1 set/clear");

    // R4 active
    wr(12'h300, 1, 2, 32'h8000_0003);
    wr(12'h380, 1, 2, 32'h0000_0002);
    rd(12'h300, 1, 2, 32'h8000_0001, "R4 active set/clear");
    rd(12'h380, 0, 2, 32'd0, "R4 R5 active banked");

    // R6 priority lanes
    wr(12'h421, 0, 0, 32'h0000_00AB);
    wr(12'h424, 0, 2, 32'h4433_2211);
    rd(12'h424, 0, 2, 32'h4433_2211, "R6 4-byte write");
    rd(12'h420, 2, 2, 32'h0000_AB00, "R6 byte write lane");
    rd(12'h421, 0, 1, 32'h0000_00AB, "R6 2-byte read");
    wr(12'h404, 1, 1, 32'h0000_BEEF);
    rd(12'h404, 1, 2, 32'h0000_BEEF, "R6 banked 2-byte write");
    rd(12'h404, 0, 2, 32'd0, "R6 banked other cpu");
    chk(32'(prio_o[(1*NL+5)*8 +: 8]), 32'h0000_00BE, "R6 prio view");
    wr(12'h45E, 0, 2, 32'h5566_7788);
    rd(12'h45C, 0, 2, 32'h7788_0000, "R6 lanes past last line dropped");

    // R7 bad size
    wr(12'h420, 0, 3, 32'hFFFF_FFFF);
    chk({31'd0, err_o}, 32'd1, "R7 err pulse");
    @(negedge clk);
    chk({31'd0, err_o}, 32'd0, "R7 err one cycle");
    rd(12'h420, 0, 2, 32'h0000_AB00, "R7 no change");

    // R8 targets
    wr(12'h800, 0, 2, 32'h0F0F_0F0F);
    rd(12'h800, 2, 2, 32'h0404_0404, "R8 low targets fixed");
    wr(12'h820, 0, 2, 32'h0402_0104);
    rd(12'h820, 1, 2, 32'h0402_0104, "R8 target store");
    chk(32'(target_o[(0*NL+32)*8 +: 8]), 32'h0000_0004, "R8 target view");

    // R9 config
    wr(12'hC04, 0, 2, 32'hA5A5_0000);
    rd(12'hC04, 1, 2, 32'hA5A5_0000, "R9 config word");
    chk(config_o[32 +: 32], 32'hA5A5_0000, "R9 config view");

    // R10 type
    wr(12'h004, 0, 2, 32'hFFFF_FFFF);
    rd(12'h004, 0, 2, 32'h0000_0042, "R10 type value");

    // R11 peripheral pulses
    periph_set_i[40] = 1'b1; periph_set_i[20] = 1'b1;
    @(negedge clk);
    periph_set_i = '0;
    rd(12'h204, 2, 2, 32'h0000_01F0, "R11 pulse sets shared pending");
    rd(12'h200, 1, 2, 32'd0, "R11 low pulse ignored");
    periph_set_i[41] = 1'b1;
    wr(12'h284, 0, 2, 32'h0000_0200);
    periph_set_i = '0;
    rd(12'h284, 0, 2, 32'h0000_03F0, "R11 pulse wins over clear");
    chk({31'd0, pending_o[2*NL+40]}, 32'd1, "R11 pending view");

    // R12 unmapped
    rd(12'h00C, 0, 2, 32'd0, "R12 unmapped read");
    wr(12'h10C, 0, 2, 32'hFFFF_FFFF);
    rd(12'h10C, 0, 2, 32'd0, "R12 out-of-range word");
    wr(12'hC18, 0, 2, 32'hFFFF_FFFF);
    rd(12'hC18, 0, 2, 32'd0, "R12 out-of-range config");
    wr(12'hF00, 0, 2, 32'hFFFF_FFFF);
    rd(12'hF00, 0, 2, 32'd0, "R12 unmapped write ignored");

    // R13 hold
    rd(12'h104, 0, 2, 32'hAAAA_5555, "R13 read");
    repeat (3) @(negedge clk);
    chk(rdata_o, 32'hAAAA_5555, "R13 rdata holds");

    @(negedge clk);
    finish_run();
  end
endmodule